// File: doc/BRIEF.md
# Windowed Watchdog Timer with Debug Masking

This block is a memory-mapped watchdog. A 16-bit down counter is stepped by a two-stage clock divider: first a programmable 8-bit prescaler, then a fixed power-of-two stage chosen from four settings. When the counter runs out, it reloads itself from a data register and raises a latched interrupt and/or a one-cycle reset request. The counter only steps while software has enabled it and an external count-enable input is high.

Two protections sit on top of the plain timeout. In window mode, software may only reload the count once it has fallen to or below a programmable minimum. A reload that arrives too early counts as a violation and has the same effect as a timeout. A debug-acknowledge input can also hide both alarm outputs while a control bit allows it, so that a halted processor is not reset under a debugger.

Software reads and writes registers through a simple select/write-enable bus whose read data is combinational. The five registers are control, reload data, current count, interrupt clear and window minimum.

Top module: `wdog_window`

## Requirements
- R1: After reset the control register reads 0x00000021 (counting and reset request enabled, prescale 0, divide-by-16). Reload data and count read 0x8000, the minimum reads 0xFFFF, the clear register reads 0, and irq and rst_req are low.
- R2: The register offsets are: control at 0x00, reload data at 0x04 (16 bits), count at 0x08, interrupt clear at 0x0C (reads 0), and minimum at 0x10 (16 bits). Only control bits 0, 2, 3, 4, 5, 8 to 15, 16 and 20 are stored, and the other control bits read 0. Any other offset reads 0.
- R3: With prescale P in control[15:8] and divider code D in control[4:3] (0, 1, 2, 3 give 16, 32, 64, 128), the count steps once every (P+1)·(16·2^D) clock cycles.
- R4: The count and both divider stages hold their values while control bit 5 is low or count_en is low.
- R5: A step taken while the count is 0 is an expiry. The count reloads from the data register and an alarm event fires.
- R6: On an alarm event with control bit 2 set, the interrupt latches high and stays high until any write to offset 0x0C. A new event in the same cycle as a clear wins.
- R7: On an alarm event with control bit 0 set, rst_req is high for exactly one cycle, starting at the clock edge that takes the event.
- R8: With control bits 20 and 5 set, a write to the count register while the count is above the minimum is a violation. It fires an alarm event and loads the reload data instead of the written value.
- R9: A count write that is not a violation loads the written value and fires nothing. This covers window mode off, and window mode on with the count at or below the minimum.
- R10: While control bit 16 and dbg_ack are both high, irq and rst_req are forced low. A latched interrupt shows again once dbg_ack falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| count_en | input | 1 | External permission to count |
| dbg_ack | input | 1 | Debug acknowledge, hides alarms when enabled |
| irq | output | 1 | Latched interrupt (masked view) |
| rst_req | output | 1 | One-cycle reset request (masked view) |

## Verification
Read data depends only on bus_addr and register state within the same cycle. A register write is seen at the edge that samples it. An alarm event, whether from an expiring step or a violating count write, shows on irq and rst_req right after the edge that takes the step or the write. Debug masking acts combinationally on the current dbg_ack. The bench steps a behavioural model at each rising edge from the inputs it has just sampled. It then compares irq, rst_req and bus_rdata one nanosecond later, which is after the design's registers have settled and before any input moves at the falling edge. Directed checks use the same sampling point, and they stop the counter with count_en whenever an exact count value must be read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int DIV_W  = 7;

    localparam int OFF_CTRL = 'h00;
    localparam int OFF_DATA = 'h04;
    localparam int OFF_CNT  = 'h08;
    localparam int OFF_CLR  = 'h0C;
    localparam int OFF_MIN  = 'h10;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0011_FF3D;
    localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0021;
    localparam logic [CNT_W-1:0]  DATA_RESET = 16'h8000;
    localparam logic [CNT_W-1:0]  MIN_RESET  = 16'hFFFF;

    typedef struct packed {
        logic             win;
        logic             dbg_mask;
        logic [PRE_W-1:0] pre;
        logic             run_en;
        logic [1:0]       dsel;
        logic             irq_en;
        logic             rst_en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(logic [DATA_W-1:0] r);
        ctrl_t c;
        c.rst_en   = r[0];
        c.irq_en   = r[2];
        c.dsel     = r[4:3];
        c.run_en   = r[5];
        c.pre      = r[15:8];
        c.dbg_mask = r[16];
        c.win      = r[20];
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] div_last(logic [1:0] code);
        return DIV_W'((32'd16 << code) - 32'd1);
    endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
#(
    parameter int PW = PRE_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] pre,
    input  logic [1:0]    dsel,
    output logic          tick
);
    logic [PW-1:0] pcnt;
    logic [DW-1:0] dcnt;
    logic [DW-1:0] dlim;
    logic          ptick;

    always_comb begin
        dlim  = DW'(div_last(dsel));
        ptick = run && (pcnt >= pre);
        tick  = ptick && (dcnt >= dlim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (run) begin
            pcnt <= ptick ? '0 : pcnt + 1'b1;
            if (ptick)
                dcnt <= tick ? '0 : dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          win_on,
    input  logic          wr_cnt,
    input  logic [CW-1:0] wr_val,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] min_cnt,
    output logic [CW-1:0] count,
    output logic          fire
);
    logic expire, viol;
    logic [CW-1:0] nxt;

    always_comb begin
        viol   = wr_cnt && win_on && (count > min_cnt);
        expire = tick && !wr_cnt && (count == '0);
        fire   = viol || expire;
        if (wr_cnt)
            nxt = viol ? reload : wr_val;
        else if (tick)
            nxt = (count == '0) ? reload : count - 1'b1;
        else
            nxt = count;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= CW'(DATA_RESET);
        else     count <= nxt;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     count,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl,
    output logic [CW-1:0]     reload,
    output logic [CW-1:0]     min_cnt,
    output logic              wr_cnt,
    output logic              wr_clr
);
    logic [DATA_W-1:0] ctrl_r;
    logic wr;

    always_comb begin
        wr     = sel && we;
        wr_cnt = wr && (addr == AW'(OFF_CNT));
        wr_clr = wr && (addr == AW'(OFF_CLR));
        ctrl   = unpack_ctrl(ctrl_r);
        case (addr)
            AW'(OFF_CTRL): rdata = ctrl_r;
            AW'(OFF_DATA): rdata = DATA_W'(reload);
            AW'(OFF_CNT):  rdata = DATA_W'(count);
            AW'(OFF_MIN):  rdata = DATA_W'(min_cnt);
            default:       rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r  <= CTRL_RESET;
            reload  <= CW'(DATA_RESET);
            min_cnt <= CW'(MIN_RESET);
        end else if (wr) begin
            if (addr == AW'(OFF_CTRL)) ctrl_r  <= wdata & CTRL_KEEP;
            if (addr == AW'(OFF_DATA)) reload  <= wdata[CW-1:0];
            if (addr == AW'(OFF_MIN))  min_cnt <= wdata[CW-1:0];
        end
    end
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic irq_en,
    input  logic rst_en,
    input  logic wr_clr,
    input  logic mask,
    output logic irq_q,
    output logic irq,
    output logic rst_req
);
    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            if (fire && irq_en) irq_q <= 1'b1;
            else if (wr_clr)    irq_q <= 1'b0;
            rst_q <= fire && rst_en;
        end
    end

    always_comb begin
        irq     = irq_q && !mask;
        rst_req = rst_q && !mask;
    end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              count_en,
    input  logic              dbg_ack,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] count, reload, min_cnt;
    logic             wr_cnt, wr_clr, tick, fire, irq_q, run, mask;

    assign run  = ctrl.run_en && count_en;
    assign mask = ctrl.dbg_mask && dbg_ack;

    wdog_regs u_regs (
        .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .count(count), .rdata(bus_rdata), .ctrl(ctrl),
        .reload(reload), .min_cnt(min_cnt), .wr_cnt(wr_cnt), .wr_clr(wr_clr)
    );

    wdog_tick u_tick (
        .clk(clk), .rst(rst), .run(run), .pre(ctrl.pre), .dsel(ctrl.dsel),
        .tick(tick)
    );

    wdog_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .win_on(ctrl.win && ctrl.run_en),
        .wr_cnt(wr_cnt), .wr_val(bus_wdata[CNT_W-1:0]), .reload(reload),
        .min_cnt(min_cnt), .count(count), .fire(fire)
    );

    wdog_alarm u_alarm (
        .clk(clk), .rst(rst), .fire(fire), .irq_en(ctrl.irq_en),
        .rst_en(ctrl.rst_en), .wr_clr(wr_clr), .mask(mask), .irq_q(irq_q),
        .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] min_cnt,
    input logic             tick,
    input logic             wr_cnt,
    input logic             wr_clr,
    input logic             fire,
    input logic             irq_q,
    input logic             irq,
    input logic             rst_req,
    input logic             dbg_ack
);
    // R4: without a step or a count write the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(count));

    // R3: a step on a nonzero count decrements by one
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && count != '0) |=> (count == CNT_W'($past(count) - 1'b1)));

    // R5: a step at zero reloads from the data register
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_cnt && count == '0) |=> (count == $past(reload)));

    // R8: an early count write in window mode latches the interrupt when enabled
    a_r8_early: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && ctrl.win && ctrl.run_en && count > min_cnt && ctrl.irq_en) |=> irq_q);

    // R6: a clear with no competing event drops the latched interrupt
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !(fire && ctrl.irq_en)) |=> !irq_q);

    // R7: a reset request only follows an alarm event
    a_r7_cause: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(fire));

    // R10: debug masking hides both outputs
    a_r10_mask: assert property (@(posedge clk) disable iff (rst)
        (ctrl.dbg_mask && dbg_ack) |-> (!irq && !rst_req));
endmodule

bind wdog_window wdog_window_chk u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl), .count(count), .reload(reload),
    .min_cnt(min_cnt), .tick(tick), .wr_cnt(wr_cnt), .wr_clr(wr_clr),
    .fire(fire), .irq_q(irq_q), .irq(irq), .rst_req(rst_req), .dbg_ack(dbg_ack)
);

// File: tb/wdog_window_test.sv
`timescale 1ns/1ps
module wdog_window_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        count_en = 1'b0, dbg_ack = 1'b0;
    logic        irq, rst_req;

    int vectors = 0, fails = 0;

    wdog_window uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_en(count_en), .dbg_ack(dbg_ack), .irq(irq), .rst_req(rst_req)
    );

    always #2 clk = ~clk;

    // behavioural reference state
    logic [31:0] m_ctrl;
    int m_data, m_cnt, m_min, m_pc, m_dc, nc, lim;
    bit m_irq, m_rst, run, ptk, tk, wr, wc, viol, expd, fire;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'h00: return m_ctrl;
            5'h04: return 32'(m_data);
            5'h08: return 32'(m_cnt);
            5'h10: return 32'(m_min);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 32'h21; m_data = 'h8000; m_cnt = 'h8000; m_min = 'hFFFF;
            m_pc = 0; m_dc = 0; m_irq = 0; m_rst = 0;
        end else begin
            run = m_ctrl[5] && count_en;
            ptk = 0; tk = 0;
            if (run) begin
                if (m_pc >= int'(m_ctrl[15:8])) begin m_pc = 0; ptk = 1; end
                else m_pc++;
            end
            if (ptk) begin
                lim = (16 << m_ctrl[4:3]) - 1;
                if (m_dc >= lim) begin m_dc = 0; tk = 1; end
                else m_dc++;
            end
            wr   = bus_sel && bus_we;
            wc   = wr && bus_addr == 5'h08;
            viol = wc && m_ctrl[20] && m_ctrl[5] && (m_cnt > m_min);
            expd = tk && !wc && m_cnt == 0;
            fire = viol || expd;
            if (wc) nc = viol ? m_data : int'(bus_wdata[15:0]);
            else if (tk) nc = (m_cnt == 0) ? m_data : m_cnt - 1;
            else nc = m_cnt;
            if (fire && m_ctrl[2]) m_irq = 1;
            else if (wr && bus_addr == 5'h0C) m_irq = 0;
            m_rst = fire && m_ctrl[0];
            if (wr && bus_addr == 5'h00) m_ctrl = bus_wdata & 32'h0011_FF3D;
            if (wr && bus_addr == 5'h04) m_data = int'(bus_wdata[15:0]);
            if (wr && bus_addr == 5'h10) m_min  = int'(bus_wdata[15:0]);
            m_cnt = nc;
        end
        #1;
        if (!rst) begin
            check("R6 irq vs model", 32'(irq), 32'(m_irq && !(m_ctrl[16] && dbg_ack)));
            check("R7 rst_req vs model", 32'(rst_req), 32'(m_rst && !(m_ctrl[16] && dbg_ack)));
            check("R2 rdata vs model", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr_reg(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd_reg(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(posedge clk);
        #1 v = bus_rdata;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        int n, s;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd_reg(5'h00, a); check("R1 ctrl reset", a, 32'h21);
        rd_reg(5'h04, a); check("R1 data reset", a, 32'h8000);
        rd_reg(5'h08, a); check("R1 count reset", a, 32'h8000);
        rd_reg(5'h0C, a); check("R1 clear reads 0", a, 0);
        rd_reg(5'h10, a); check("R1 min reset", a, 32'hFFFF);
        check("R1 irq low", 32'(irq), 0);
        check("R1 rst_req low", 32'(rst_req), 0);

        // R3 step period: prescale 2, divide code 1 -> 3*32 cycles
        count_en = 1;
        wr_reg(5'h00, 32'h0000_022D);
        wr_reg(5'h04, 32'h100);
        wr_reg(5'h08, 32'h100);
        rd_reg(5'h08, a);
        n = 0;
        do begin rd_reg(5'h08, b); n++; end while (b == a && n < 400);
        a = b; n = 0;
        do begin rd_reg(5'h08, b); n++; end while (b == a && n < 400);
        check("R3 step period", 32'(n), 32'd96);

        // R4 hold while count_en low
        @(negedge clk) count_en = 0;
        rd_reg(5'h08, a);
        repeat (300) @(posedge clk);
        rd_reg(5'h08, b);
        check("R4 count held", b, a);

        // R5 expiry and R6 latch/clear
        @(negedge clk) count_en = 1;
        wr_reg(5'h00, 32'h25);
        wr_reg(5'h04, 32'h2);
        wr_reg(5'h08, 32'h1);
        n = 0;
        while (!irq && n < 200) begin after_edge(); n++; end
        check("R5 expiry fires irq", 32'(irq), 1);
        @(negedge clk) count_en = 0;
        rd_reg(5'h08, a); check("R5 reload after expiry", a, 32'h2);
        repeat (40) @(posedge clk);
        #1 check("R6 irq stays latched", 32'(irq), 1);
        wr_reg(5'h0C, 0);
        #1 check("R6 irq cleared", 32'(irq), 0);

        // R8 early write in window mode
        wr_reg(5'h04, 32'h40);
        wr_reg(5'h08, 32'h30);
        wr_reg(5'h10, 32'h4);
        wr_reg(5'h00, 32'h0010_0025);
        wr_reg(5'h08, 32'h3);
        rd_reg(5'h08, a); check("R8 violation loads reload", a, 32'h40);
        check("R8 violation raises irq", 32'(irq), 1);

        // R9 permitted writes
        wr_reg(5'h0C, 0);
        wr_reg(5'h10, 32'hFFFF);
        wr_reg(5'h08, 32'h3);
        rd_reg(5'h08, a); check("R9 in-window write loads value", a, 32'h3);
        check("R9 no irq on permitted write", 32'(irq), 0);
        wr_reg(5'h00, 32'h25);
        wr_reg(5'h10, 32'h0);
        wr_reg(5'h08, 32'h9);
        rd_reg(5'h08, a); check("R9 window off write loads value", a, 32'h9);
        check("R9 no irq with window off", 32'(irq), 0);

        // R7 one-cycle reset request
        wr_reg(5'h00, 32'h0010_0025);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = 5'h08; bus_wdata = 32'h5;
        after_edge(); s = int'(rst_req);
        @(negedge clk); bus_sel = 0; bus_we = 0;
        for (int i = 0; i < 3; i++) begin after_edge(); s += int'(rst_req); end
        check("R7 rst_req single cycle", 32'(s), 1);

        // R10 debug masking
        wr_reg(5'h0C, 0);
        wr_reg(5'h00, 32'h0011_0025);
        @(negedge clk) dbg_ack = 1;
        wr_reg(5'h08, 32'h5);
        #1 check("R10 irq hidden under debug", 32'(irq), 0);
        @(negedge clk) dbg_ack = 0;
        #1 check("R10 irq returns after debug", 32'(irq), 1);

        // R2 control keeps only implemented bits
        wr_reg(5'h00, 32'hFFFF_FFFF);
        rd_reg(5'h00, a); check("R2 control bit mask", a, 32'h0011_FF3D);
        rd_reg(5'h14, a); check("R2 unmapped offset", a, 0);

        @(negedge clk);
        bus_sel = 0;
        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule